// File: doc/BRIEF.md
# Fade-Tolerant Lock Supervisor

This block is the control state machine that sits between a satellite demodulator's acquisition logic and the downstream error-correction chain. It follows the lock flags from the timing loop, the carrier loop, the gain loop and the FEC. It starts acquisition on a host command. It declares tracking once the three demodulator loops are all locked.

A fade or a cycle slip is handled in a set order. The demodulator is held in tracking so that the FEC can resynchronise by itself, for example by rotating its phase. Only when FEC lock stays lost past a host-programmed timeout does the supervisor pulse a demodulator restart and acquire again. Acquisition can run with preset signal parameters or blind; the mode is captured at each entry to acquisition.

A debug mode makes every state change wait for a host step pulse. A sticky interrupt status register records every rising and falling edge of the four lock flags. Its bits are cleared by writing 1, and it drives a maskable interrupt line.

Top module: `lock_supervisor`

## Requirements
- R1: After reset, fsmState is IDLE (code 0), intStatus is 0, irq is 0 and demodRestart is 0.
- R2: In IDLE, startCmd moves the state to ACQUIRE (code 1) at the next clock. acqBlind then holds the blindMode value sampled on that transition.
- R3: ACQUIRE moves to TRACK (code 2) only in a cycle where timingLock, carrierLock and agcLock are all high.
- R4: TRACK moves to FEC_WAIT (code 3) when fecLock is low. Losing a demodulator lock while fecLock stays high leaves the state in TRACK.
- R5: If fecLock returns while in FEC_WAIT, the state goes back to TRACK. The timeout count restarts from zero on the next entry to FEC_WAIT.
- R6: With timeoutCfg = N and fecLock held low, REACQUIRE (code 4) is first seen N*PRESCALE+1 cycles after FEC_WAIT is first seen (PRESCALE defaults to 1024). N = 0 gives 1 cycle.
- R7: REACQUIRE lasts exactly one cycle with demodRestart high. The state then enters ACQUIRE and acqBlind captures blindMode again.
- R8: While debugMode is high, the state changes only at a clock where stepPulse is high.
- R9: intStatus bit i (i = 0 timing, 1 carrier, 2 AGC, 3 FEC) sets on a rising edge of that lock flag. Bit i+4 sets on its falling edge. Set bits stay set until cleared.
- R10: With intClrWe high, each 1 in intClrData clears the matching intStatus bit. A new edge in the same cycle wins over the clear.
- R11: irq is high exactly when some bit of intStatus AND intMask is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCmd | input | 1 | Host command to begin acquisition from IDLE |
| blindMode | input | 1 | 1 = blind acquisition, 0 = preset parameters |
| debugMode | input | 1 | Gate every state change on stepPulse |
| stepPulse | input | 1 | Host single-step strobe |
| timingLock | input | 1 | Timing loop locked |
| carrierLock | input | 1 | Carrier loop locked |
| agcLock | input | 1 | Gain loop locked |
| fecLock | input | 1 | FEC synchronised |
| timeoutCfg | input | 16 | FEC regain timeout in prescaler units |
| intMask | input | 8 | Interrupt enable per status bit |
| intClrWe | input | 1 | Status clear strobe |
| intClrData | input | 8 | Write-1-to-clear mask |
| fsmState | output | 3 | Current state code |
| acqBlind | output | 1 | Acquisition mode captured at entry |
| demodRestart | output | 1 | Demodulator restart pulse |
| intStatus | output | 8 | Sticky lock edge status |
| irq | output | 1 | Masked interrupt |

## Verification
Two functions can meet in the same clock. A lock flag can toggle in the very cycle the host writes a clear to the bit that edge sets. A directed case drops timing lock together with a clear of its falling bit, and the bit must read set afterwards. Random stimulus then mixes lock toggles and clear writes against a bench model that applies set-over-clear. Timeout expiry is judged by counting the exact cycles from FEC_WAIT entry to REACQUIRE, including an early FEC return that must restart the count.

// File: rtl/lock_sup_pkg.sv
package lock_sup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACQ     = 3'd1,
    ST_TRACK   = 3'd2,
    ST_FECWAIT = 3'd3,
    ST_REACQ   = 3'd4
  } supState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic clrTimer;
    logic runTimer;
  } timerCtl_t;

  localparam int NUM_LOCKS = 4;
endpackage

// File: rtl/lsv_datapath.sv
module lsv_datapath
  import lock_sup_pkg::*;
#(
  parameter int PRESCALE  = 1024,
  parameter int TIMEOUT_W = 16,
  parameter int N_LOCK    = NUM_LOCKS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  timerCtl_t             timerCtl,
  input  logic [TIMEOUT_W-1:0]  timeoutCfg,
  input  logic [N_LOCK-1:0]     lockIn,
  input  logic [2*N_LOCK-1:0]   intMask,
  input  logic                  intClrWe,
  input  logic [2*N_LOCK-1:0]   intClrData,
  output logic                  timeoutHit,
  output logic [2*N_LOCK-1:0]   intStatus,
  output logic                  irq
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam int ST_W = 2 * N_LOCK;

  logic [PRE_W-1:0]     preCnt;
  logic [TIMEOUT_W-1:0] unitCnt;
  logic [N_LOCK-1:0]    lockPrev;
  logic [ST_W-1:0]      setVec;
  logic [ST_W-1:0]      clrVec;

  // prescaled timeout counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN || timerCtl.clrTimer) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (timerCtl.runTimer) begin
      if (preCnt == PRE_LAST) begin
        preCnt <= '0;
        if (unitCnt != '1) unitCnt <= unitCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign timeoutHit = (unitCnt >= timeoutCfg);

  // edge detection per lock flag
  always_ff @(posedge clk) begin
    if (!rstN) lockPrev <= '0;
    else       lockPrev <= lockIn;
  end

  for (genvar gi = 0; gi < N_LOCK; gi++) begin : g_edge
    assign setVec[gi]          = lockIn[gi] & ~lockPrev[gi];
    assign setVec[gi + N_LOCK] = ~lockIn[gi] & lockPrev[gi];
  end

  assign clrVec = intClrWe ? intClrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) intStatus <= '0;
    else       intStatus <= (intStatus & ~clrVec) | setVec;
  end

  assign irq = |(intStatus & intMask);

  // R9: without a clear write no status bit may drop
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !intClrWe |=> ((intStatus & $past(intStatus)) == $past(intStatus)));

  // R5: leaving the wait state restarts the timeout from zero
  a_r5_timer_clear: assert property (@(posedge clk) disable iff (!rstN)
    timerCtl.clrTimer |=> (unitCnt == '0 && preCnt == '0));

  // R10: a fresh edge is never lost to a clear in the same cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (lockIn[0] != lockPrev[0]) |=> (intStatus[0] | intStatus[N_LOCK]));
endmodule

// File: rtl/lsv_ctrl.sv
module lsv_ctrl
  import lock_sup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startCmd,
  input  logic      blindMode,
  input  logic      debugMode,
  input  logic      stepPulse,
  input  logic      demodLocked,
  input  logic      fecLock,
  input  logic      timeoutHit,
  output supState_t state,
  output timerCtl_t timerCtl,
  output logic      acqBlind,
  output logic      demodRestart
);
  supState_t nextState;
  logic      advance;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (startCmd)    nextState = ST_ACQ;
      ST_ACQ:     if (demodLocked) nextState = ST_TRACK;
      ST_TRACK:   if (!fecLock)    nextState = ST_FECWAIT;
      ST_FECWAIT: begin
        if (fecLock)         nextState = ST_TRACK;
        else if (timeoutHit) nextState = ST_REACQ;
      end
      ST_REACQ:   nextState = ST_ACQ;
      default:    nextState = ST_IDLE;
    endcase
  end

  assign advance = !debugMode || stepPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      acqBlind <= 1'b0;
    end else if (advance) begin
      state <= nextState;
      if (nextState == ST_ACQ && state != ST_ACQ) acqBlind <= blindMode;
    end
  end

  assign timerCtl.clrTimer = (state != ST_FECWAIT);
  assign timerCtl.runTimer = (state == ST_FECWAIT);
  assign demodRestart      = (state == ST_REACQ);

  // R7: restart state lasts a single cycle when not single-stepping
  a_r7_reacq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REACQ && !debugMode) |=> (state == ST_ACQ));

  // R8: without a step pulse the debug mode freezes the state
  a_r8_debug_hold: assert property (@(posedge clk) disable iff (!rstN)
    (debugMode && !stepPulse) |=> $stable(state));

  // R4: tracking survives while the FEC stays locked
  a_r4_track_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRACK && fecLock) |=> (state == ST_TRACK));

  // R2: idle only leaves on a start command
  a_r2_idle_waits: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !startCmd) |=> (state == ST_IDLE));
endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor
  import lock_sup_pkg::*;
#(
  parameter int PRESCALE  = 1024,
  parameter int TIMEOUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startCmd,
  input  logic                   blindMode,
  input  logic                   debugMode,
  input  logic                   stepPulse,
  input  logic                   timingLock,
  input  logic                   carrierLock,
  input  logic                   agcLock,
  input  logic                   fecLock,
  input  logic [TIMEOUT_W-1:0]   timeoutCfg,
  input  logic [2*NUM_LOCKS-1:0] intMask,
  input  logic                   intClrWe,
  input  logic [2*NUM_LOCKS-1:0] intClrData,
  output logic [2:0]             fsmState,
  output logic                   acqBlind,
  output logic                   demodRestart,
  output logic [2*NUM_LOCKS-1:0] intStatus,
  output logic                   irq
);
  supState_t stateQ;
  timerCtl_t timerCtl;
  logic      timeoutHit;
  logic      demodLocked;

  assign demodLocked = timingLock & carrierLock & agcLock;
  assign fsmState    = stateQ;

  lsv_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startCmd    (startCmd),
    .blindMode   (blindMode),
    .debugMode   (debugMode),
    .stepPulse   (stepPulse),
    .demodLocked (demodLocked),
    .fecLock     (fecLock),
    .timeoutHit  (timeoutHit),
    .state       (stateQ),
    .timerCtl    (timerCtl),
    .acqBlind    (acqBlind),
    .demodRestart(demodRestart)
  );

  lsv_datapath #(
    .PRESCALE (PRESCALE),
    .TIMEOUT_W(TIMEOUT_W),
    .N_LOCK   (NUM_LOCKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .timerCtl  (timerCtl),
    .timeoutCfg(timeoutCfg),
    .lockIn    ({fecLock, agcLock, carrierLock, timingLock}),
    .intMask   (intMask),
    .intClrWe  (intClrWe),
    .intClrData(intClrData),
    .timeoutHit(timeoutHit),
    .intStatus (intStatus),
    .irq       (irq)
  );
endmodule

// File: tb/test_lock_supervisor.sv
module test_lock_supervisor;
  logic        clk = 1'b0;
  logic        rstN;
  logic        startCmd, blindMode, debugMode, stepPulse;
  logic        timingLock, carrierLock, agcLock, fecLock;
  logic [15:0] timeoutCfg;
  logic [7:0]  intMask, intClrData;
  logic        intClrWe;
  logic [2:0]  fsmState;
  logic        acqBlind, demodRestart, irq;
  logic [7:0]  intStatus;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  lock_supervisor i_lock_supervisor (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .blindMode(blindMode),
    .debugMode(debugMode), .stepPulse(stepPulse), .timingLock(timingLock),
    .carrierLock(carrierLock), .agcLock(agcLock), .fecLock(fecLock),
    .timeoutCfg(timeoutCfg), .intMask(intMask), .intClrWe(intClrWe),
    .intClrData(intClrData), .fsmState(fsmState), .acqBlind(acqBlind),
    .demodRestart(demodRestart), .intStatus(intStatus), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // bench model of the status register (R9, R10)
  function automatic logic [7:0] nextStat(input logic [7:0] cur, input logic [3:0] prev,
                                          input logic [3:0] now, input logic we,
                                          input logic [7:0] clr);
    logic [7:0] setBits;
    setBits = {prev & ~now, now & ~prev};
    return (cur & ~(we ? clr : 8'h00)) | setBits;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] expStat;
    logic [3:0] prevL, newL;
    int cnt;
    void'($urandom(32'd4711));
    rstN = 0; startCmd = 0; blindMode = 0; debugMode = 0; stepPulse = 0;
    timingLock = 0; carrierLock = 0; agcLock = 0; fecLock = 0;
    timeoutCfg = 16'd2; intMask = 8'h00; intClrWe = 0; intClrData = 8'h00;
    repeat (4) tick();
    rstN = 1;
    tick();
    check("R1 state", fsmState, 0);
    check("R1 status", intStatus, 0);
    check("R1 irq", irq, 0);
    check("R1 restart", demodRestart, 0);

    startCmd = 1; blindMode = 1;
    tick();
    startCmd = 0;
    check("R2 acquire", fsmState, 1);
    check("R2 blind", acqBlind, 1);

    timingLock = 1; carrierLock = 1;
    repeat (3) tick();
    check("R3 partial lock stays", fsmState, 1);
    agcLock = 1; fecLock = 1;
    tick();
    check("R3 track", fsmState, 2);

    carrierLock = 0;
    repeat (2) tick();
    check("R4 demod loss holds track", fsmState, 2);
    carrierLock = 1;
    fecLock = 0;
    tick();
    check("R4 fec wait", fsmState, 3);
    repeat (500) tick();
    check("R5 still waiting", fsmState, 3);
    fecLock = 1;
    tick();
    check("R5 back to track", fsmState, 2);

    fecLock = 0; blindMode = 0;
    tick();
    check("R5 wait again", fsmState, 3);
    cnt = 0;
    while (fsmState != 3'd4 && cnt < 5000) begin
      tick();
      cnt++;
    end
    check("R6 expiry cycles", cnt, 2 * 1024 + 1);
    check("R7 restart pulse", demodRestart, 1);
    tick();
    check("R7 to acquire", fsmState, 1);
    check("R7 blind recapture", acqBlind, 0);
    check("R7 pulse ends", demodRestart, 0);

    fecLock = 1;
    tick();
    check("R3 relock", fsmState, 2);
    timeoutCfg = 16'd0; fecLock = 0;
    tick();
    check("R6 zero wait", fsmState, 3);
    tick();
    check("R6 zero timeout", fsmState, 4);

    debugMode = 1; fecLock = 1;
    repeat (3) tick();
    check("R8 hold in restart", fsmState, 4);
    stepPulse = 1;
    tick();
    stepPulse = 0;
    check("R8 step to acquire", fsmState, 1);
    repeat (3) tick();
    check("R8 hold in acquire", fsmState, 1);
    stepPulse = 1;
    tick();
    stepPulse = 0;
    check("R8 step to track", fsmState, 2);

    // clear everything, then set-versus-clear collision
    intClrWe = 1; intClrData = 8'hFF;
    tick();
    intClrWe = 0;
    check("R10 clear all", intStatus, 0);
    timingLock = 0; intClrWe = 1; intClrData = 8'h10;
    tick();
    intClrWe = 0;
    check("R10 edge beats clear", intStatus, 8'h10);
    timingLock = 1;
    tick();
    check("R9 rising timing", intStatus, 8'h11);
    intMask = 8'h01;
    tick();
    check("R11 irq masked in", irq, 1);
    intMask = 8'h02;
    tick();
    check("R11 irq masked out", irq, 0);
    intClrWe = 1; intClrData = 8'hFF;
    tick();
    intClrWe = 0;
    check("R10 clear again", intStatus, 0);

    expStat = 8'h00;
    prevL = {fecLock, agcLock, carrierLock, timingLock};
    for (int i = 0; i < 400; i++) begin
      check("R9 random status", intStatus, expStat);
      check("R11 random irq", irq, |(expStat & intMask));
      newL = prevL ^ (($urandom % 3 == 0) ? 4'($urandom) : 4'h0);
      {fecLock, agcLock, carrierLock, timingLock} = newL;
      intClrWe   = ($urandom % 3 == 0);
      intClrData = 8'($urandom);
      intMask    = 8'($urandom);
      expStat = nextStat(expStat, prevL, newL, intClrWe, intClrData);
      prevL = newL;
      tick();
    end
    check("R8 state frozen in debug", fsmState, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule